// File: doc/BRIEF.md
# Start-up sequencer with bus address strapping and init interrupt

This block governs the first moments of a host-controlled peripheral that sits on a two-wire bus. While reset is held, it reads two strap pins and turns them into the 7-bit slave address the bus slave must answer to. It also presents a set of power-on default settings to the rest of the device.

Once reset is released, it waits a fixed time and then pulls an active-low interrupt line. This tells the host that the device has not yet been set up. A status read issued by the host returns a code whose "not initialised" flag is set. When the host sends its write-configuration command, the flag clears. The interrupt is let go after a second fixed delay.

Both delays are given in microseconds and converted to clock counts from a clock-frequency parameter. Commands arrive already decoded, as one-cycle pulses from the bus slave.

Top module: `init_irq_ctrl`

## Requirements
- R1: The address is 7'b1000010 plus the two-bit value {strap_hi, strap_lo}, so 00, 01, 10 and 11 give 0x42, 0x43, 0x44 and 0x45. It is taken at the last rising clock edge at which rst_n is low. addr_byte_wr is {address, 1'b0} and addr_byte_rd is {address, 1'b1}.
- R2: Once rst_n is high, changes on strap_hi and strap_lo have no effect on bus_addr, addr_byte_wr or addr_byte_rd.
- R3: irq_n is 1 while in reset and stays 1 up to the rising edge that is N_ASSERT edges after rst_n goes high. It falls to 0 at that edge, where N_ASSERT = ceil(CLK_HZ*ASSERT_US/1e6).
- R4: irq_n stays 0 until a write-configuration command arrives. The command is a cmd_wrcfg high at a rising edge. noinit drops to 0 at that edge, and irq_n returns to 1 at the edge that is N_RELEASE edges later, where N_RELEASE = ceil(CLK_HZ*RELEASE_US/1e6).
- R5: A write-configuration command captured at or before the edge where irq_n would fall cancels the assertion. irq_n then stays 1 until the next reset.
- R6: A second write-configuration command arriving while the release delay runs restarts it. irq_n then rises N_RELEASE edges after the latest command.
- R7: A cmd_rdint high at a rising edge gives int_vld = 1 for exactly the next cycle. In that cycle int_code bit 0 holds the NOINIT flag as it was before that edge, and int_code bits 7..1 are 0.
- R8: noinit is 1 after reset. After a write-configuration command it is 0 and stays 0 until the next reset.
- R9: After reset the configuration outputs hold these defaults:
  - cfg_pwm_div = 64
  - cfg_kp_rows = 3
  - cfg_kp_cols = 3
  - cfg_mux_en = 0
  - cfg_irq_en = 1
  - cfg_irq_act_hi = 0
  - cfg_debounce = 3
  - cfg_active_ms = 500

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| strap_hi | input | 1 | Upper address-select strap |
| strap_lo | input | 1 | Lower address-select strap |
| cmd_wrcfg | input | 1 | Decoded write-configuration command pulse |
| cmd_rdint | input | 1 | Decoded read-interrupt-status command pulse |
| irq_n | output | 1 | Active-low interrupt request |
| noinit | output | 1 | Device not yet configured by host |
| int_code | output | 8 | Interrupt status code, bit 0 = NOINIT |
| int_vld | output | 1 | int_code valid strobe |
| bus_addr | output | 7 | Latched slave address |
| addr_byte_wr | output | 8 | First bus byte for a write |
| addr_byte_rd | output | 8 | First bus byte for a read |
| cfg_pwm_div | output | 8 | Default PWM clock divider |
| cfg_kp_rows | output | 4 | Default keypad rows |
| cfg_kp_cols | output | 4 | Default keypad columns |
| cfg_mux_en | output | 1 | Default digital multiplexer enable |
| cfg_irq_en | output | 1 | Default interrupt enable |
| cfg_irq_act_hi | output | 1 | Default interrupt polarity, 0 = active low |
| cfg_debounce | output | 4 | Default debounce, in scan cycles |
| cfg_active_ms | output | 10 | Default active time, in ms |

## Verification
The bench sweeps all four strap codes, and for each code it runs three start-up histories:
- **Normal hand-shake.** The bench checks the exact edges at which irq_n falls and rises. A timer off by one would move either edge.
- **Early command.** The command comes before the assertion point. A design that forgot to cancel the pending assertion would pull irq_n low anyway.
- **Repeated command.** A second command arrives during the release wait. A design that failed to restart the timer would release one delay after the first command.

In each history, strap toggles after reset must leave the address unchanged; a latch that kept sampling would show the new code. Status reads taken before and after configuration show whether the NOINIT bit is reported from the right moment.

// File: rtl/init_pkg.sv
package init_pkg;

  localparam logic [6:0] ADDR_BASE = 7'b1000010;

  typedef struct packed {
    logic [7:0] pwm_div;
    logic [3:0] kp_rows;
    logic [3:0] kp_cols;
    logic       mux_en;
    logic       irq_en;
    logic       irq_act_hi;
    logic [3:0] debounce;
    logic [9:0] active_ms;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{
    pwm_div:    8'd64,
    kp_rows:    4'd3,
    kp_cols:    4'd3,
    mux_en:     1'b0,
    irq_en:     1'b1,
    irq_act_hi: 1'b0,
    debounce:   4'd3,
    active_ms:  10'd500
  };

  // Microseconds to clock cycles, rounded up, at least one cycle.
  function automatic int cycles_for(input longint hz, input longint us);
    longint c;
    c = (hz * us + 64'sd999999) / 64'sd1000000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  // Strap code to 7-bit slave address.
  function automatic logic [6:0] addr_for(input logic [1:0] sel);
    return ADDR_BASE + {5'b00000, sel};
  endfunction

endpackage

// File: rtl/strap_addr_latch.sv
module strap_addr_latch
  import init_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] straps,
  output logic [6:0] addr,
  output logic [7:0] byte_wr,
  output logic [7:0] byte_rd
);

  // Follows the straps only while reset is low; frozen once it is high.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= addr_for(straps);
      byte_wr <= {addr_for(straps), 1'b0};
      byte_rd <= {addr_for(straps), 1'b1};
    end
  end

  a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(addr) && $stable(byte_wr) && $stable(byte_rd));

  a_r1_dir_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr[7:1] == byte_rd[7:1]) && !byte_wr[0] && byte_rd[0]);

endmodule

// File: rtl/dly_timer.sv
module dly_timer #(
  parameter int CYCLES     = 100,
  parameter bit START_BUSY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic expire,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  // Abort beats start, and start beats expiry, so a restart never fires early.
  assign expire = busy && (cnt == '0) && !start && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= START_BUSY;
      cnt  <= LOAD;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LOAD));

  a_r6_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> (busy && cnt == LOAD && !expire));

endmodule

// File: rtl/init_seq.sv
module init_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wrcfg,
  input  logic       cmd_rdint,
  input  logic       assert_expire,
  input  logic       release_expire,
  output logic       irq_n,
  output logic       noinit,
  output logic [7:0] int_code,
  output logic       int_vld
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n    <= 1'b1;
      noinit   <= 1'b1;
      int_code <= 8'h00;
      int_vld  <= 1'b0;
    end else begin
      if (assert_expire)       irq_n <= 1'b0;
      else if (release_expire) irq_n <= 1'b1;
      if (cmd_wrcfg) noinit <= 1'b0;
      int_vld <= cmd_rdint;
      if (cmd_rdint) int_code <= {7'b0000000, noinit};
    end
  end

  a_r3_fall_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(assert_expire));

  a_r4_rise_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(release_expire));

  a_r5_no_assert_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrcfg && irq_n) |=> irq_n);

  a_r8_noinit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !noinit |=> !noinit);

  a_r7_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rdint |=> (int_vld && int_code[0] == $past(noinit) && int_code[7:1] == 7'd0));

endmodule

// File: rtl/cfg_defaults.sv
module cfg_defaults
  import init_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output cfg_t cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= CFG_DEFAULT;
    else        cfg <= cfg;
  end

  a_r9_defaults_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg));

endmodule

// File: rtl/init_irq_ctrl.sv
module init_irq_ctrl
  import init_pkg::*;
#(
  parameter longint CLK_HZ     = 10000000,
  parameter longint ASSERT_US  = 100,
  parameter longint RELEASE_US = 90
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_hi,
  input  logic       strap_lo,
  input  logic       cmd_wrcfg,
  input  logic       cmd_rdint,
  output logic       irq_n,
  output logic       noinit,
  output logic [7:0] int_code,
  output logic       int_vld,
  output logic [6:0] bus_addr,
  output logic [7:0] addr_byte_wr,
  output logic [7:0] addr_byte_rd,
  output logic [7:0] cfg_pwm_div,
  output logic [3:0] cfg_kp_rows,
  output logic [3:0] cfg_kp_cols,
  output logic       cfg_mux_en,
  output logic       cfg_irq_en,
  output logic       cfg_irq_act_hi,
  output logic [3:0] cfg_debounce,
  output logic [9:0] cfg_active_ms
);

  localparam int N_ASSERT  = cycles_for(CLK_HZ, ASSERT_US);
  localparam int N_RELEASE = cycles_for(CLK_HZ, RELEASE_US);

  logic assert_expire, assert_busy;
  logic release_expire, release_busy;
  cfg_t cfg;

  strap_addr_latch u_addr (
    .clk(clk), .rst_n(rst_n), .straps({strap_hi, strap_lo}),
    .addr(bus_addr), .byte_wr(addr_byte_wr), .byte_rd(addr_byte_rd)
  );

  // Runs from reset release; a configuration command cancels it.
  dly_timer #(.CYCLES(N_ASSERT), .START_BUSY(1'b1)) u_assert_tmr (
    .clk(clk), .rst_n(rst_n), .start(1'b0), .abort(cmd_wrcfg),
    .expire(assert_expire), .busy(assert_busy)
  );

  // Started, or restarted, by each configuration command.
  dly_timer #(.CYCLES(N_RELEASE), .START_BUSY(1'b0)) u_release_tmr (
    .clk(clk), .rst_n(rst_n), .start(cmd_wrcfg), .abort(1'b0),
    .expire(release_expire), .busy(release_busy)
  );

  init_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wrcfg(cmd_wrcfg), .cmd_rdint(cmd_rdint),
    .assert_expire(assert_expire), .release_expire(release_expire),
    .irq_n(irq_n), .noinit(noinit), .int_code(int_code), .int_vld(int_vld)
  );

  cfg_defaults u_cfg (.clk(clk), .rst_n(rst_n), .cfg(cfg));

  assign cfg_pwm_div    = cfg.pwm_div;
  assign cfg_kp_rows    = cfg.kp_rows;
  assign cfg_kp_cols    = cfg.kp_cols;
  assign cfg_mux_en     = cfg.mux_en;
  assign cfg_irq_en     = cfg.irq_en;
  assign cfg_irq_act_hi = cfg.irq_act_hi;
  assign cfg_debounce   = cfg.debounce;
  assign cfg_active_ms  = cfg.active_ms;

  a_r5_timers_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(assert_busy && release_busy));

  a_r4_release_only_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    release_busy |-> !noinit);

endmodule

// File: tb/sim_init_irq_ctrl.sv
module sim_init_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 20;
  localparam int NR = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_hi = 1'b0, strap_lo = 1'b0, cmd_wrcfg = 1'b0, cmd_rdint = 1'b0;
  logic irq_n, noinit, int_vld, cfg_mux_en, cfg_irq_en, cfg_irq_act_hi;
  logic [7:0] int_code, addr_byte_wr, addr_byte_rd, cfg_pwm_div;
  logic [6:0] bus_addr;
  logic [3:0] cfg_kp_rows, cfg_kp_cols, cfg_debounce;
  logic [9:0] cfg_active_ms;

  int tests = 0, fails = 0, ecount = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  init_irq_ctrl #(.CLK_HZ(1000000), .ASSERT_US(NA), .RELEASE_US(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .strap_lo(strap_lo),
    .cmd_wrcfg(cmd_wrcfg), .cmd_rdint(cmd_rdint), .irq_n(irq_n),
    .noinit(noinit), .int_code(int_code), .int_vld(int_vld),
    .bus_addr(bus_addr), .addr_byte_wr(addr_byte_wr), .addr_byte_rd(addr_byte_rd),
    .cfg_pwm_div(cfg_pwm_div), .cfg_kp_rows(cfg_kp_rows), .cfg_kp_cols(cfg_kp_cols),
    .cfg_mux_en(cfg_mux_en), .cfg_irq_en(cfg_irq_en), .cfg_irq_act_hi(cfg_irq_act_hi),
    .cfg_debounce(cfg_debounce), .cfg_active_ms(cfg_active_ms)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1; ecount++;
  endtask

  task automatic adv_to(input int e);
    while (ecount < e) tick();
  endtask

  task automatic wrcfg();
    cmd_wrcfg = 1'b1; tick(); cmd_wrcfg = 1'b0;
  endtask

  task automatic rdint(input string req, input int exp_bit);
    cmd_rdint = 1'b1; tick(); cmd_rdint = 1'b0;
    check(req, {int_vld, int_code}, {1'b1, 7'd0, exp_bit[0]});
    tick();
    check({req, " strobe one cycle"}, int_vld, 0);
  endtask

  task automatic do_reset(input logic [1:0] sel);
    rst_n = 1'b0; strap_hi = sel[1]; strap_lo = sel[0];
    repeat (3) begin @(posedge clk); #1; end
    check("R3 irq_n in reset", irq_n, 1);
    check("R8 noinit in reset", noinit, 1);
    rst_n = 1'b1; strap_hi = ~sel[1]; strap_lo = ~sel[0];
    ecount = 0;
  endtask

  task automatic check_addr(input logic [1:0] sel);
    int exp;
    exp = 66 + int'(sel);
    check("R1 bus_addr", bus_addr, exp);
    check("R1 addr_byte_wr", addr_byte_wr, exp * 2);
    check("R1 addr_byte_rd", addr_byte_rd, exp * 2 + 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      for (int sc = 0; sc < 3; sc++) begin
        logic [1:0] sel;
        int e;
        bit bad;
        sel = 2'(s);
        do_reset(sel);
        tick();
        check_addr(sel);
        check("R9 pwm_div", cfg_pwm_div, 64);
        check("R9 keypad", {cfg_kp_rows, cfg_kp_cols}, 8'h33);
        check("R9 flags", {cfg_mux_en, cfg_irq_en, cfg_irq_act_hi}, 3'b010);
        check("R9 debounce", cfg_debounce, 3);
        check("R9 active_ms", cfg_active_ms, 500);
        strap_hi = sel[0]; strap_lo = ~sel[1];
        if (sc == 0) begin
          adv_to(NA - 1);
          check("R3 irq_n before assert point", irq_n, 1);
          tick();
          check("R3 irq_n at assert point", irq_n, 0);
          rdint("R7 read before config", 1);
          wrcfg(); e = ecount;
          check("R8 noinit after cmd", noinit, 0);
          check("R4 irq_n held after cmd", irq_n, 0);
          adv_to(e + NR - 1);
          check("R4 irq_n before release", irq_n, 0);
          tick();
          check("R4 irq_n at release", irq_n, 1);
          rdint("R7 read after config", 0);
        end else if (sc == 1) begin
          adv_to(4 + s);
          wrcfg();
          bad = 0;
          while (ecount < NA + NR + 5) begin
            tick();
            if (irq_n !== 1'b1) bad = 1;
          end
          check("R5 early cmd suppresses irq", bad, 0);
          check("R8 noinit after early cmd", noinit, 0);
        end else begin
          adv_to(NA);
          check("R3 irq_n asserted", irq_n, 0);
          wrcfg(); e = ecount;
          adv_to(e + 4);
          wrcfg(); e = ecount;
          adv_to(e + NR - 1);
          check("R6 irq_n held after restart", irq_n, 0);
          tick();
          check("R6 irq_n released after restart", irq_n, 1);
          rdint("R8 flag stays clear", 0);
        end
        check_addr(sel);
        check("R2 straps ignored", bus_addr, 66 + s);
      end
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule